// File: doc/BRIEF.md
# PWM Emergency Brake Controller

This block sits between a timer's channel generators and the output pins and forces the PWM outputs to safe levels when an emergency occurs. Two sources can trip it: an external brake pin, whose active level is programmable, and a clock-failure event from a clock supervisor. Once the brake function is armed, either source takes the main output enable away straight away, through a combinational path that does not wait for a clock edge. While the brake condition lasts, every channel is held at its inactive level.

A synchronized copy of the brake pin sets a sticky status flag. The flag drives an interrupt line and a DMA request line, and each of these has its own enable. The main output enable can be restored by software with a set strobe. It can also be restored automatically on the next timer update event when the auto-enable bit is on. Both ways are refused while a brake is still present. Writes to the arm and polarity bits pass through a pending stage, so they take effect one cycle after the write is accepted.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: After a synchronous reset the main enable, status flag, interrupt and DMA lines are 0. The arm and polarity read-backs are 0. Every channel output equals its idle bit.
- R2: With the arm bit at 1, the brake pin is active when it is 1 if the polarity bit is 0, and when it is 0 if the polarity bit is 1. With the arm bit at 0, neither the pin nor the clock-fail input has any effect.
- R3: When a configuration write is strobed before clock edge k, the read-back still shows the old arm and polarity values after edge k. It shows the new values after edge k+1.
- R4: A clock-fail pulse with the arm bit at 1 acts as a brake. It clears the main enable and sets the status flag at the next edge.
- R5: An active brake drops the main enable output within the same cycle, with no clock edge needed. The main enable then stays low after the brake source goes away.
- R6: Each channel has a polarity bit p (1 = active low) and a raw input r (1 = active). With the main enable at 1, the output is r XOR p. During a brake, the output is p, its inactive level. With the main enable at 0 and no brake, the output is the channel's idle bit.
- R7: The status flag is set SYNC_STAGES+1 edges after the brake pin becomes active. It stays set until a clear strobe, and a new brake event wins over the clear. The interrupt line equals flag AND interrupt-enable. The DMA line equals flag AND DMA-enable.
- R8: With the auto-enable bit at 1 and no brake present, an update event sets the main enable at the next edge. With the auto-enable bit at 0, an update event leaves it at 0.
- R9: While a brake is present, neither an update event nor the software set strobe raises the main enable.
- R10: A software set strobe with no brake present sets the main enable at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_pin | input | 1 | External brake pin |
| clk_fail | input | 1 | Clock-failure event pulse |
| cfg_wr | input | 1 | Write strobe for arm/polarity |
| cfg_arm | input | 1 | Arm value to write |
| cfg_pol | input | 1 | Brake polarity value to write (1 = active low) |
| rd_arm | output | 1 | Read-back of the applied arm bit |
| rd_pol | output | 1 | Read-back of the applied polarity bit |
| auto_oe | input | 1 | Re-enable on update event |
| oe_set | input | 1 | Software strobe that sets the main enable |
| flag_clr | input | 1 | Clears the status flag |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| upd_evt | input | 1 | Timer update event pulse |
| ch_raw | input | NUM_CH | Raw channel waveforms, 1 = active |
| ch_pol | input | NUM_CH | Per-channel polarity, 1 = active low |
| ch_idle | input | NUM_CH | Per-channel idle level |
| ch_out | output | NUM_CH | Gated channel outputs |
| main_oe | output | 1 | Effective main output enable |
| brk_flag | output | 1 | Sticky brake status flag |
| brk_irq | output | 1 | Interrupt request |
| brk_dma | output | 1 | DMA request |

## Verification
The bench builds the block with NUM_CH = 3 and SYNC_STAGES = 3. The odd channel count gives mixed polarities, so an inactive level of 1 sits next to an inactive level of 0. The three-stage synchronizer lets the bench tell the asynchronous drop of the main enable apart from the flag, which comes four edges later, and pin down both cycles exactly. Because the synchronizer depth is not the default, the generated stage chain is checked at a depth other than the default.

// File: rtl/pwm_brake_pkg.sv
`timescale 1ns/1ps
package pwm_brake_pkg;

    typedef struct packed {
        logic arm;
        logic pol;
    } brk_cfg_t;

    // Level driven on one channel pin for the given gating state.
    function automatic logic chan_level(
        input logic oe,
        input logic brk,
        input logic raw,
        input logic pol,
        input logic idle
    );
        logic lvl;
        if (brk)
            lvl = pol;          // inactive level of this channel
        else if (oe)
            lvl = raw ^ pol;
        else
            lvl = idle;
        return lvl;
    endfunction

endpackage

// File: rtl/brake_cfg_reg.sv
`timescale 1ns/1ps
module brake_cfg_reg
    import pwm_brake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  brk_cfg_t wdata,
    output brk_cfg_t cfg
);
    logic     pend_v;
    brk_cfg_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
            cfg    <= '0;
        end else begin
            if (pend_v)
                cfg <= pend;
            pend_v <= wr;
            if (wr)
                pend <= wdata;
        end
    end

    // R3: a pending value lands exactly one edge after capture
    p_cfg_delay_r3: assert property (@(posedge clk) disable iff (rst)
        pend_v |=> (cfg == $past(pend)));

endmodule

// File: rtl/brake_detect.sv
`timescale 1ns/1ps
module brake_detect
    import pwm_brake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  brk_cfg_t cfg,
    input  logic     pin,
    input  logic     clk_fail,
    output logic     brk_now,
    output logic     brk_evt
);
    logic [SYNC_STAGES-1:0] stage;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= 1'b0;
                    else     stage[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= 1'b0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    // Unsynchronized path: gates the outputs without waiting for a clock.
    assign brk_now = cfg.arm & ((pin ^ cfg.pol) | clk_fail);
    // Synchronized path: feeds the status flag.
    assign brk_evt = cfg.arm & ((stage[SYNC_STAGES-1] ^ cfg.pol) | clk_fail);

    // R2: disarmed detector never reports
    p_disarmed_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg.arm |-> (!brk_now && !brk_evt));

endmodule

// File: rtl/brake_oe_ctrl.sv
`timescale 1ns/1ps
module brake_oe_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic brk_now,
    input  logic brk_evt,
    input  logic upd_evt,
    input  logic auto_oe,
    input  logic oe_set,
    input  logic flag_clr,
    output logic main_oe,
    output logic flag
);
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst)
            oe_q <= 1'b0;
        else if (brk_now)
            oe_q <= 1'b0;
        else if (oe_set || (upd_evt && auto_oe))
            oe_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (brk_evt)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    assign main_oe = oe_q & ~brk_now;

    // R1: reset leaves enable and flag low
    p_reset_r1: assert property (@(posedge clk) rst |=> (!oe_q && !flag));
    // R5: a brake seen at an edge keeps the enable low afterwards
    p_oe_clear_r5: assert property (@(posedge clk) disable iff (rst)
        brk_now |=> !oe_q);
    // R9: no re-enable while braking
    p_no_reenable_r9: assert property (@(posedge clk) disable iff (rst)
        (brk_now && !$past(oe_q)) |=> !oe_q);
    // R8: auto re-enable with no brake
    p_auto_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_evt && auto_oe && !brk_now) |=> oe_q);
    // R7: event wins over clear
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> flag);

endmodule

// File: rtl/brake_out_gate.sv
`timescale 1ns/1ps
module brake_out_gate
    import pwm_brake_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              main_oe,
    input  logic              brk_now,
    input  logic [NUM_CH-1:0] raw,
    input  logic [NUM_CH-1:0] pol,
    input  logic [NUM_CH-1:0] idle,
    output logic [NUM_CH-1:0] out
);
    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign out[c] = chan_level(main_oe, brk_now, raw[c], pol[c], idle[c]);

            // R6: never at the active level while braking
            p_no_active_r6: assert property (@(posedge clk) disable iff (rst)
                brk_now |-> (out[c] != ~pol[c]));
        end
    endgenerate

endmodule

// File: rtl/pwm_brake_ctrl.sv
`timescale 1ns/1ps
module pwm_brake_ctrl
    import pwm_brake_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_pin,
    input  logic              clk_fail,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_pol,
    output logic              rd_arm,
    output logic              rd_pol,
    input  logic              auto_oe,
    input  logic              oe_set,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              dma_en,
    input  logic              upd_evt,
    input  logic [NUM_CH-1:0] ch_raw,
    input  logic [NUM_CH-1:0] ch_pol,
    input  logic [NUM_CH-1:0] ch_idle,
    output logic [NUM_CH-1:0] ch_out,
    output logic              main_oe,
    output logic              brk_flag,
    output logic              brk_irq,
    output logic              brk_dma
);
    brk_cfg_t wcfg, cfg;
    logic     brk_now, brk_evt;

    assign wcfg.arm = cfg_arm;
    assign wcfg.pol = cfg_pol;

    brake_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (wcfg),
        .cfg   (cfg)
    );

    brake_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .pin      (brk_pin),
        .clk_fail (clk_fail),
        .brk_now  (brk_now),
        .brk_evt  (brk_evt)
    );

    brake_oe_ctrl u_oe (
        .clk      (clk),
        .rst      (rst),
        .brk_now  (brk_now),
        .brk_evt  (brk_evt),
        .upd_evt  (upd_evt),
        .auto_oe  (auto_oe),
        .oe_set   (oe_set),
        .flag_clr (flag_clr),
        .main_oe  (main_oe),
        .flag     (brk_flag)
    );

    brake_out_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .main_oe (main_oe),
        .brk_now (brk_now),
        .raw     (ch_raw),
        .pol     (ch_pol),
        .idle    (ch_idle),
        .out     (ch_out)
    );

    assign rd_arm  = cfg.arm;
    assign rd_pol  = cfg.pol;
    assign brk_irq = brk_flag & irq_en;
    assign brk_dma = brk_flag & dma_en;

    // R5: with the pin active and armed the enable output is low at once
    p_async_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_arm && (brk_pin ^ rd_pol)) |-> !main_oe);

endmodule

// File: tb/pwm_brake_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_brake_ctrl_tb;
    localparam int NCH  = 3;
    localparam int SYNC = 3;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst, brk_pin, clk_fail, cfg_wr, cfg_arm, cfg_pol;
    logic auto_oe, oe_set, flag_clr, irq_en, dma_en, upd_evt;
    logic [NCH-1:0] ch_raw, ch_pol, ch_idle, ch_out;
    logic rd_arm, rd_pol, main_oe, brk_flag, brk_irq, brk_dma;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_brake_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(SYNC)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; brk_pin = 1'b1; clk_fail = 1'b0; cfg_wr = 1'b0;
        cfg_arm = 1'b0; cfg_pol = 1'b0; auto_oe = 1'b0; oe_set = 1'b0;
        flag_clr = 1'b0; irq_en = 1'b1; dma_en = 1'b0; upd_evt = 1'b0;
        ch_raw = 3'b011; ch_pol = 3'b010; ch_idle = 3'b101;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 main_oe", main_oe, 0);
        chk("R1 flag", brk_flag, 0);
        chk("R1 irq", brk_irq, 0);
        chk("R1 readback", {rd_arm, rd_pol}, 0);
        chk("R1 idle outputs", ch_out, 3'b101);
    endtask

    task automatic t_disarmed_set;
        // pin high with arm=0, pol=0 must be ignored
        oe_set = 1'b1; step(1); oe_set = 1'b0;
        chk("R10 software set", main_oe, 1);
        clk_fail = 1'b1; step(1); clk_fail = 1'b0;
        step(LAT + 2);
        chk("R2 disarmed main_oe", main_oe, 1);
        chk("R2 disarmed flag", brk_flag, 0);
        chk("R6 enabled outputs", ch_out, 3'b011 ^ 3'b010);
        ch_raw = 3'b100; #1;
        chk("R6 enabled outputs 2", ch_out, 3'b100 ^ 3'b010);
    endtask

    task automatic t_cfg_delay;
        cfg_wr = 1'b1; cfg_arm = 1'b1; cfg_pol = 1'b1;   // active low, pin high
        step(1); cfg_wr = 1'b0;
        chk("R3 old readback", {rd_arm, rd_pol}, 2'b00);
        step(1);
        chk("R3 new readback", {rd_arm, rd_pol}, 2'b11);
        step(LAT + 1);
        chk("R2 inactive polarity", main_oe, 1);
        chk("R2 inactive flag", brk_flag, 0);
    endtask

    task automatic t_pin_brake;
        brk_pin = 1'b0; #1;
        chk("R5 async drop", main_oe, 0);
        chk("R6 brake outputs", ch_out, 3'b010);
        step(LAT - 1);
        chk("R7 flag not yet", brk_flag, 0);
        step(1);
        chk("R7 flag latency", brk_flag, 1);
        chk("R7 irq", brk_irq, 1);
        chk("R7 dma off", brk_dma, 0);
        auto_oe = 1'b1; upd_evt = 1'b1; oe_set = 1'b1;
        step(1);
        upd_evt = 1'b0; oe_set = 1'b0; auto_oe = 1'b0;
        chk("R9 blocked", main_oe, 0);
        chk("R6 brake outputs held", ch_out, 3'b010);
    endtask

    task automatic t_release_auto;
        brk_pin = 1'b1;
        step(3);
        chk("R5 stays low", main_oe, 0);
        chk("R6 idle after brake", ch_out, 3'b101);
        chk("R7 sticky", brk_flag, 1);
        upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        chk("R8 no auto", main_oe, 0);
        auto_oe = 1'b1; upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        chk("R8 auto re-enable", main_oe, 1);
        auto_oe = 1'b0;
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R7 flag cleared", brk_flag, 0);
        chk("R7 irq cleared", brk_irq, 0);
    endtask

    task automatic t_clk_fail;
        dma_en = 1'b1;
        clk_fail = 1'b1; flag_clr = 1'b1; #1;
        chk("R4 async drop", main_oe, 0);
        step(1);
        clk_fail = 1'b0; flag_clr = 1'b0;
        chk("R4 flag wins", brk_flag, 1);
        chk("R7 dma", brk_dma, 1);
        step(2);
        chk("R4 stays low", main_oe, 0);
    endtask

    task automatic t_polarity_high;
        cfg_wr = 1'b1; cfg_arm = 1'b1; cfg_pol = 1'b0;   // active high, pin high
        step(1); cfg_wr = 1'b0;
        chk("R3 old pol", rd_pol, 1);
        step(1);
        chk("R3 new pol", rd_pol, 0);
        oe_set = 1'b1; step(1); oe_set = 1'b0;
        chk("R2 high pin brakes", main_oe, 0);
        brk_pin = 1'b0; oe_set = 1'b1; step(1); oe_set = 1'b0;
        chk("R10 set after release", main_oe, 1);
    endtask

    initial begin
        t_reset();
        t_disarmed_set();
        t_cfg_delay();
        t_pin_brake();
        t_release_auto();
        t_clk_fail();
        t_polarity_high();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule